// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous, bit-serial character stream on one input wire into parallel bytes. Each character opens with a LOW start bit. Eight data bits follow, least significant first, and a HIGH stop bit closes the character. Between characters the wire rests HIGH. No clock travels with the data, so the receiver oversamples the wire at eight ticks per bit period. It locks onto the middle of the start bit and then takes every later bit near its centre.

The block is clocked by the system clock. A single-cycle tick input marks each oversampling instant. When the tick is held HIGH continuously, the clock itself is the 8x sampling clock. When the tick pulses once every N cycles, a faster clock can drive the block. The serial wire passes through a two-flop synchronizer before any decision is made on it. A completed byte is presented on the parallel output together with a one-cycle ready strobe. The byte stays there until the next good character arrives. An output-enable input masks the data bus to zero.

Top module: `serial_byte_rx`

## Requirements
- R1: A character is a LOW start bit, eight data bits with bit 0 sent first, then a HIGH stop bit. The received byte appears on `data_o` with the first data bit in bit 0.
- R2: `valid_o` is HIGH for exactly one clock cycle for each accepted character, in the same cycle that the new byte first appears on `data_o`.
- R3: After the synchronized line is first seen LOW on a tick, the start bit is confirmed only if the line is still LOW on the 4th tick after that. If it is HIGH there, the receiver returns to idle and issues no strobe.
- R4: After confirmation, each of the eight data bits and the stop bit is sampled 8 ticks after the previous sample.
- R5: A start bit that directly follows the previous stop bit, with no idle time between them, is received, and so is the character it begins.
- R6: A stop bit sampled LOW discards the character and issues no strobe. The receiver then ignores the line until it is seen HIGH on a tick, and only after that looks for a new start bit.
- R7: While `oe_i` is LOW, `data_o` is all zeros. The stored byte is kept and reappears when `oe_i` returns HIGH.
- R8: While `rst_i` is HIGH, and in the first cycle after it is released, `valid_o` is LOW and `data_o` is zero. The receiver then waits in idle.
- R9: The receiver state changes only on clock edges where `tick_i` is HIGH. A character whose bit period is 8 ticks, with ticks spaced several clocks apart, is received correctly.
- R10: `data_o` holds the last accepted byte, unchanged, until the next strobe, provided `oe_i` stays HIGH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling enable, one pulse per 1/8 bit period |
| rx_i | input | 1 | Asynchronous serial line, HIGH when idle |
| oe_i | input | 1 | Output enable for the data bus |
| data_o | output | 8 | Last accepted byte, zero while disabled |
| valid_o | output | 1 | One-cycle strobe for each accepted byte |

## Verification
The ready strobe and the output-enable mask can coincide in the same cycle. The bench provokes this by dropping `oe_i` for a whole character. The strobe must still fire, the bus must read zero in that cycle, and the stored byte must then reappear unchanged once `oe_i` rises. A second collision comes from back-to-back characters. There, the stop-bit acceptance of one character and the start-edge detection of the next fall within a few ticks of each other. Every character must then be strobed once, with the right byte, and the strobe count must match the number of well-formed characters sent.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_WAIT  = 3'd4
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int  STAGES   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= {STAGES{RST_VAL}};
        else       chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_o
);
    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_i) begin
            sr_d = {bit_i, sr_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sr_q <= '0;
        else       sr_q <= sr_d;
    end

    assign word_o = sr_q;
endmodule

// File: rtl/rx_out.sv
module rx_out #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic             oe_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load_i) hold_d = word_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) hold_q <= '0;
        else       hold_q <= hold_d;
    end

    assign data_o = oe_i ? hold_q : '0;
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
    import rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              oe_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int HALF  = OVERSAMPLE / 2;
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             strobe;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: RX_IDLE, cnt: '0, idx: '0, strobe: 1'b0};

    ctl_t ctl_d, ctl_q;
    logic line_s;
    logic shift_en;
    logic accept;
    logic [DATA_W-1:0] word;

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    assign state_q = ctl_q.st;
    assign cnt_q   = ctl_q.cnt;

    rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (rx_i),
        .q_o   (line_s)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.strobe = 1'b0;
        shift_en     = 1'b0;
        accept       = 1'b0;
        if (tick_i) begin
            unique case (ctl_q.st)
                RX_IDLE: begin
                    if (!line_s) begin
                        ctl_d.st  = RX_START;
                        ctl_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (ctl_q.cnt == CNT_HALF) begin
                        ctl_d.cnt = '0;
                        ctl_d.idx = '0;
                        ctl_d.st  = line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (ctl_q.cnt == CNT_LAST) begin
                        shift_en  = 1'b1;
                        ctl_d.cnt = '0;
                        if (ctl_q.idx == IDX_LAST) ctl_d.st  = RX_STOP;
                        else                       ctl_d.idx = ctl_q.idx + 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (ctl_q.cnt == CNT_LAST) begin
                        ctl_d.cnt = '0;
                        if (line_s) begin
                            accept       = 1'b1;
                            ctl_d.strobe = 1'b1;
                            ctl_d.st     = RX_IDLE;
                        end else begin
                            ctl_d.st = RX_WAIT;
                        end
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                RX_WAIT: begin
                    if (line_s) ctl_d.st = RX_IDLE;
                end
                default: ctl_d = CTL_RST;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ctl_q <= CTL_RST;
        else       ctl_q <= ctl_d;
    end

    rx_shift #(.WIDTH(DATA_W)) shift_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (shift_en),
        .bit_i   (line_s),
        .word_o  (word)
    );

    rx_out #(.WIDTH(DATA_W)) out_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (accept),
        .word_i (word),
        .oe_i   (oe_i),
        .data_o (data_o)
    );

    assign valid_o = ctl_q.strobe;
endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk
    import rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 8,
    localparam int CNT_W     = $clog2(OVERSAMPLE)
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              tick_i,
    input logic              oe_i,
    input logic              line_s,
    input rx_state_e         state_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              valid_o,
    input logic [DATA_W-1:0] data_o
);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVERSAMPLE / 2 - 1);

    p_strobe_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    p_strobe_after_stop_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> ($past(state_q) == RX_STOP && $past(tick_i) && $past(line_s)));

    p_glitch_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == RX_START && tick_i && cnt_q == CNT_HALF && line_s) |=> state_q == RX_IDLE);

    p_wait_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == RX_WAIT && !line_s) |=> state_q == RX_WAIT);

    p_tick_gate_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> (state_q == $past(state_q) && cnt_q == $past(cnt_q)));

    p_data_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (oe_i && $past(oe_i) && !valid_o) |-> $stable(data_o));
endmodule

bind serial_byte_rx serial_byte_rx_chk #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .oe_i    (oe_i),
    .line_s  (line_s),
    .state_q (state_q),
    .cnt_q   (cnt_q),
    .valid_o (valid_o),
    .data_o  (data_o)
);

// File: tb/serial_byte_rx_tb_top.sv
`timescale 1ns/1ps
module serial_byte_rx_tb_top;
    localparam int DIV = 3;
    localparam int BIT_CLKS = 8 * DIV;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic tick_i = 1'b0;
    logic rx_i = 1'b1;
    logic oe_i = 1'b1;
    logic [7:0] data_o;
    logic valid_o;

    int n_checks = 0;
    int n_fail = 0;
    int strobe_cnt = 0;
    int wr_idx = 0;
    int rd_idx = 0;
    logic [7:0] exp_mem [0:255];
    logic prev_valid = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    serial_byte_rx dut_i (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .tick_i  (tick_i),
        .rx_i    (rx_i),
        .oe_i    (oe_i),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] masked(input logic [7:0] b, input logic en);
        return en ? b : 8'h00;
    endfunction

    // tick generator: one pulse every DIV clocks
    initial begin
        forever begin
            for (int k = 0; k < DIV; k++) begin
                @(negedge clk);
                tick_i = (k == DIV - 1);
            end
        end
    end

    // monitor: compares every strobe against the next expected byte
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_i && valid_o) begin
                strobe_cnt++;
                check(!prev_valid, "R2", int'(prev_valid), 0);
                if (rd_idx < wr_idx) begin
                    check(data_o == masked(exp_mem[rd_idx[7:0]], oe_i), "R1",
                          int'(data_o), int'(masked(exp_mem[rd_idx[7:0]], oe_i)));
                end else begin
                    check(1'b0, "R6", strobe_cnt, wr_idx);
                end
                rd_idx++;
            end
            prev_valid = valid_o;
        end
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_ok);
        rx_i = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            rx_i = b[i];
            wait_clks(BIT_CLKS);
        end
        rx_i = stop_ok;
        if (stop_ok) begin
            exp_mem[wr_idx[7:0]] = b;
            wr_idx++;
        end
        wait_clks(BIT_CLKS);
    endtask

    task automatic idle_ticks(input int n);
        rx_i = 1'b1;
        wait_clks(n * DIV);
    endtask

    // watchdog
    initial begin
        wait_clks(150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] b;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        wait_clks(5);
        check(valid_o == 1'b0, "R8", int'(valid_o), 0);
        check(data_o == 8'h00, "R8", int'(data_o), 0);
        rst_i = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0 && data_o == 8'h00, "R8", int'(data_o), 0);
        idle_ticks(20);

        // directed bytes, LSB-first order (R1), tick gating (R9)
        send_frame(8'h01, 1'b1); idle_ticks(10);
        send_frame(8'h80, 1'b1); idle_ticks(10);
        send_frame(8'hA5, 1'b1); idle_ticks(3);
        send_frame(8'h00, 1'b1); idle_ticks(3);
        send_frame(8'hFF, 1'b1); idle_ticks(10);
        check(strobe_cnt == wr_idx, "R9", strobe_cnt, wr_idx);

        // back-to-back frames (R5)
        send_frame(8'h3C, 1'b1);
        send_frame(8'hC3, 1'b1);
        send_frame(8'h00, 1'b1);
        send_frame(8'h7E, 1'b1);
        idle_ticks(10);
        check(strobe_cnt == wr_idx, "R5", strobe_cnt, wr_idx);

        // glitches shorter than the confirm window (R3)
        base = strobe_cnt;
        rx_i = 1'b0; wait_clks(2 * DIV);
        idle_ticks(20);
        rx_i = 1'b0; wait_clks(1 * DIV);
        idle_ticks(20);
        check(strobe_cnt == base, "R3", strobe_cnt, base);
        check(data_o == 8'h7E, "R10", int'(data_o), 32'h7E);

        // bad stop, line held low, then good frame (R6)
        base = strobe_cnt;
        send_frame(8'h5A, 1'b0);
        rx_i = 1'b0; wait_clks(12 * DIV);
        idle_ticks(8);
        check(strobe_cnt == base, "R6", strobe_cnt, base);
        send_frame(8'h96, 1'b1); idle_ticks(10);
        check(strobe_cnt == base + 1, "R6", strobe_cnt, base + 1);

        // output enable collides with strobe (R7)
        oe_i = 1'b0;
        idle_ticks(2);
        check(data_o == 8'h00, "R7", int'(data_o), 0);
        send_frame(8'hE7, 1'b1); idle_ticks(6);
        check(data_o == 8'h00, "R7", int'(data_o), 0);
        oe_i = 1'b1;
        @(negedge clk);
        check(data_o == 8'hE7, "R7", int'(data_o), 32'hE7);
        idle_ticks(30);
        check(data_o == 8'hE7, "R10", int'(data_o), 32'hE7);

        // random frames with random gaps and occasional bad stops
        for (int n = 0; n < 40; n++) begin
            b = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 5) == 0) begin
                send_frame(b, 1'b0);
                rx_i = 1'b0; wait_clks(int'($urandom_range(1, 12)) * DIV);
                idle_ticks(8);
            end else begin
                send_frame(b, 1'b1);
                if ($urandom_range(0, 2) != 0) idle_ticks(int'($urandom_range(1, 12)));
            end
        end
        idle_ticks(12);
        check(strobe_cnt == wr_idx, "R4", strobe_cnt, wr_idx);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule